// File: doc/BRIEF.md
# Pulse Period Capture Unit

This block measures the period of a digital speed-pulse input. The pulse pin is asynchronous to the block clock. It passes through a synchronizer, and an edge detector watches it for rising edges, falling edges or both, as the host selects. When a selected edge arrives, the block stores the value of a free-running 16-bit timer, together with a small count of how often that timer has wrapped, into a two-entry FIFO. It also raises an interrupt flag.

The host reads the oldest entry from the FIFO output and pops it with a strobe. It then pulses the timer clear, so the timer and its wrap count restart from zero. Each stored value is therefore the time since the last clear. The timer wraps after a programmable terminal count. The host sets that count above the longest expected period, or leaves it at all ones when the period is unknown. If a period is longer than one timer cycle, the stored wrap count extends it: the period is wraps × (terminal count + 1) + stored count.

Top module: `pulse_stamp_top`

## Requirements
- R1: `edge_mode` selects which edges of the synchronized pin are captured: 2'b01 rising only, 2'b10 falling only, 2'b11 both, 2'b00 none.
- R2: The pin passes through two synchronizer flops before edge detection. A pin change made while the timer holds value a is stored as a+2, when the timer runs without wrapping.
- R3: The timer counts up by one each cycle. In the cycle after its value is greater than or equal to `tmr_period`, it reads 0.
- R4: A wrap count increments on each timer wrap and saturates at 2^OVF_W-1. Each FIFO entry stores the wrap count alongside the timer value, and `fifo_ovf` shows it.
- R5: A `tmr_clr` pulse sets both the timer and the wrap count to zero on the next cycle.
- R6: The FIFO holds up to two entries and presents the oldest first. `fifo_level` gives the number of valid entries (0, 1 or 2), and `fifo_pop` removes the oldest entry.
- R7: A capture into a full FIFO discards the oldest entry. The level stays 2, and the newest two values remain.
- R8: While the FIFO is empty, `fifo_data` and `fifo_ovf` read zero, and a pop leaves the level at 0.
- R9: While `cap_en` is low, no edge is captured. Raising `cap_en` again with the pin steady captures nothing.
- R10: Each capture sets `irq_flag`, and `irq_clr` clears it. If a capture and a clear fall in the same cycle, the capture wins. `irq` is `irq_flag` gated by `irq_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous speed-pulse pin |
| cap_en | input | 1 | Capture enable |
| edge_mode | input | 2 | Edge selection (see R1) |
| tmr_period | input | CNT_W | Timer terminal count |
| tmr_clr | input | 1 | Clear strobe for the timer and wrap count |
| fifo_pop | input | 1 | Pop the oldest FIFO entry |
| fifo_data | output | CNT_W | Timer value of the oldest entry |
| fifo_ovf | output | OVF_W | Wrap count of the oldest entry |
| fifo_level | output | 2 | Number of valid entries |
| irq_mask | input | 1 | Interrupt enable mask |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| irq_flag | output | 1 | Capture event flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench keeps CNT_W at 16 but builds the block with OVF_W=2, so the wrap count saturates at 3. With `tmr_period` set to 7, a sweep of 41 pin-change delays crosses several timer wraps and reaches wrap-count saturation within a few dozen cycles. Each expected entry is computed as (a+2) mod 8, with the wrap count min((a+2)/8, 3). Other runs, with the terminal count at all ones, cover the four edge modes, the discard when a capture meets a full FIFO, pops on an empty FIFO, disabled capture, and a capture that arrives in the same cycle as a flag clear.

// File: rtl/pulse_stamp_pkg.sv
package pulse_stamp_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    localparam int FIFO_DEPTH = 2;
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
endpackage

// File: rtl/pstamp_edge_det.sv
module pstamp_edge_det
    import pulse_stamp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       en_i,
    input  logic [1:0] mode_i,
    output logic       hit_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } det_st_t;

    det_st_t st_d, st_q;
    edge_sel_e mode;
    logic rise, fall;

    always_comb begin
        mode    = edge_sel_e'(mode_i);
        st_d    = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_i};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        rise    = st_q.sync[SYNC_STAGES-1] & ~st_q.prev;
        fall    = ~st_q.sync[SYNC_STAGES-1] & st_q.prev;
        unique case (mode)
            EDGE_RISE: hit_o = en_i & rise;
            EDGE_FALL: hit_o = en_i & fall;
            EDGE_BOTH: hit_o = en_i & (rise | fall);
            default:   hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pstamp_timer.sv
module pstamp_timer #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [OVF_W-1:0] ovf_o
);
    localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [OVF_W-1:0] ovf;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (clr_i) begin
            st_d = '0;
        end else if (st_q.cnt >= period_i) begin
            st_d.cnt = '0;
            if (st_q.ovf != OVF_MAX) st_d.ovf = st_q.ovf + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;
endmodule

// File: rtl/pstamp_fifo2.sv
module pstamp_fifo2
    import pulse_stamp_pkg::*;
#(
    parameter int W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     din_i,
    input  logic             pop_i,
    output logic [W-1:0]     dout_o,
    output logic [LVL_W-1:0] level_o
);
    typedef struct packed {
        logic [W-1:0]     head;
        logic [W-1:0]     tail;
        logic [LVL_W-1:0] lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.lvl)
            LVL_W'(0): begin
                if (push_i) begin
                    st_d.head = din_i;
                    st_d.lvl  = LVL_W'(1);
                end
            end
            LVL_W'(1): begin
                if (push_i && pop_i) begin
                    st_d.head = din_i;
                end else if (push_i) begin
                    st_d.tail = din_i;
                    st_d.lvl  = LVL_W'(2);
                end else if (pop_i) begin
                    st_d.lvl  = LVL_W'(0);
                end
            end
            default: begin
                if (push_i) begin
                    st_d.head = st_q.tail;
                    st_d.tail = din_i;
                end else if (pop_i) begin
                    st_d.head = st_q.tail;
                    st_d.lvl  = LVL_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_o  = (st_q.lvl != '0) ? st_q.head : '0;
    assign level_o = st_q.lvl;
endmodule

// File: rtl/pulse_stamp_top.sv
module pulse_stamp_top
    import pulse_stamp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int OVF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             cap_en,
    input  logic [1:0]       edge_mode,
    input  logic [CNT_W-1:0] tmr_period,
    input  logic             tmr_clr,
    input  logic             fifo_pop,
    output logic [CNT_W-1:0] fifo_data,
    output logic [OVF_W-1:0] fifo_ovf,
    output logic [LVL_W-1:0] fifo_level,
    input  logic             irq_mask,
    input  logic             irq_clr,
    output logic             irq_flag,
    output logic             irq
);
    localparam int ENT_W = CNT_W + OVF_W;

    logic             cap_hit;
    logic [CNT_W-1:0] tmr_cnt;
    logic [OVF_W-1:0] tmr_ovf;
    logic [ENT_W-1:0] head;

    typedef struct packed {
        logic flag;
    } irq_st_t;

    irq_st_t st_d, st_q;

    pstamp_edge_det #(.SYNC_STAGES(2)) u_det (
        .clk(clk), .rst_n(rst_n), .pin_i(pulse_in),
        .en_i(cap_en), .mode_i(edge_mode), .hit_o(cap_hit)
    );

    pstamp_timer #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr),
        .period_i(tmr_period), .cnt_o(tmr_cnt), .ovf_o(tmr_ovf)
    );

    pstamp_fifo2 #(.W(ENT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(cap_hit),
        .din_i({tmr_ovf, tmr_cnt}), .pop_i(fifo_pop),
        .dout_o(head), .level_o(fifo_level)
    );

    always_comb begin
        st_d      = st_q;
        st_d.flag = cap_hit | (st_q.flag & ~irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fifo_data = head[CNT_W-1:0];
    assign fifo_ovf  = head[ENT_W-1:CNT_W];
    assign irq_flag  = st_q.flag;
    assign irq       = st_q.flag & irq_mask;
endmodule

// File: rtl/pstamp_chk.sv
module pstamp_chk #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_en,
    input logic [CNT_W-1:0] tmr_period,
    input logic             tmr_clr,
    input logic             fifo_pop,
    input logic [CNT_W-1:0] fifo_data,
    input logic [OVF_W-1:0] fifo_ovf,
    input logic [1:0]       fifo_level,
    input logic             irq_mask,
    input logic             irq_flag,
    input logic             irq,
    input logic             cap_hit,
    input logic [CNT_W-1:0] tmr_cnt,
    input logic [OVF_W-1:0] tmr_ovf
);
    localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= 2'd2); // R6
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == 2'd0) |-> (fifo_data == '0 && fifo_ovf == '0)); // R8
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == 2'd0 && !cap_hit) |=> (fifo_level == 2'd0)); // R8
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == 2'd2 && cap_hit) |=> (fifo_level == 2'd2)); // R7
    AST_TMR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_cnt >= tmr_period) |=> (tmr_cnt == '0)); // R3
    AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clr |=> (tmr_cnt == '0 && tmr_ovf == '0)); // R5
    AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf == OVF_MAX && !tmr_clr) |=> (tmr_ovf == OVF_MAX)); // R4
    AST_NO_CAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !fifo_pop) |=> $stable(fifo_level)); // R9
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> irq_flag); // R10
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mask |-> !irq); // R10
endmodule

bind pulse_stamp_top pstamp_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .tmr_period(tmr_period),
    .tmr_clr(tmr_clr), .fifo_pop(fifo_pop), .fifo_data(fifo_data),
    .fifo_ovf(fifo_ovf), .fifo_level(fifo_level), .irq_mask(irq_mask),
    .irq_flag(irq_flag), .irq(irq), .cap_hit(cap_hit),
    .tmr_cnt(tmr_cnt), .tmr_ovf(tmr_ovf)
);

// File: tb/sim_pulse_stamp_top.sv
`timescale 1ns/1ps
module sim_pulse_stamp_top;
    localparam int CNT_W = 16;
    localparam int OVF_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pulse_in = 1'b0;
    logic             cap_en = 1'b0;
    logic [1:0]       edge_mode = 2'b11;
    logic [CNT_W-1:0] tmr_period = '1;
    logic             tmr_clr = 1'b0;
    logic             fifo_pop = 1'b0;
    logic [CNT_W-1:0] fifo_data;
    logic [OVF_W-1:0] fifo_ovf;
    logic [1:0]       fifo_level;
    logic             irq_mask = 1'b0;
    logic             irq_clr = 1'b0;
    logic             irq_flag;
    logic             irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pulse_stamp_top #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .cap_en(cap_en),
        .edge_mode(edge_mode), .tmr_period(tmr_period), .tmr_clr(tmr_clr),
        .fifo_pop(fifo_pop), .fifo_data(fifo_data), .fifo_ovf(fifo_ovf),
        .fifo_level(fifo_level), .irq_mask(irq_mask), .irq_clr(irq_clr),
        .irq_flag(irq_flag), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_one();
        fifo_pop = 1'b1;
        cycles(1);
        fifo_pop = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) if (fifo_level != 0) pop_one();
    endtask

    task automatic clear_timer();
        tmr_clr = 1'b1;
        cycles(1);
        tmr_clr = 1'b0;
    endtask

    initial begin
        cycles(3);
        check("R6 reset level", fifo_level, 0);
        check("R8 reset data", fifo_data, 0);
        check("R10 reset flag", irq_flag, 0);
        rst_n = 1'b1;
        cycles(2);
        cap_en = 1'b1;

        // R2 R3 R4 R5: delay sweep with terminal count 7, wrap count saturating at 3
        tmr_period = 16'd7;
        edge_mode  = 2'b11;
        for (int a = 0; a <= 40; a++) begin
            drain();
            clear_timer();
            cycles(a);
            pulse_in = ~pulse_in;
            cycles(3);
            check("R2 level after capture", fifo_level, 1);
            check("R3 captured count", fifo_data, (a + 2) % 8);
            check("R4 R5 captured wraps", fifo_ovf,
                  ((a + 2) / 8 > 3) ? 3 : (a + 2) / 8);
            cycles(2);
        end
        drain();
        pulse_in = 1'b0;
        cycles(5);
        drain();

        // R1: each edge mode against one rising and one falling change
        tmr_period = '1;
        for (int m = 0; m < 4; m++) begin
            edge_mode = m[1:0];
            cycles(2);
            drain();
            pulse_in = 1'b1;
            cycles(5);
            check("R1 rising edge", fifo_level, m[0] ? 1 : 0);
            pulse_in = 1'b0;
            cycles(5);
            check("R1 falling edge", fifo_level, (m[0] ? 1 : 0) + (m[1] ? 1 : 0));
        end
        drain();

        // R6 R7 R8: three captures into a two-entry FIFO
        edge_mode = 2'b11;
        clear_timer();
        cycles(10);
        pulse_in = ~pulse_in;
        cycles(10);
        pulse_in = ~pulse_in;
        cycles(10);
        pulse_in = ~pulse_in;
        cycles(5);
        check("R7 level stays full", fifo_level, 2);
        check("R7 oldest dropped", fifo_data, 22);
        pop_one();
        check("R6 level after pop", fifo_level, 1);
        check("R6 second entry", fifo_data, 32);
        pop_one();
        check("R6 empty", fifo_level, 0);
        pop_one();
        check("R8 pop on empty level", fifo_level, 0);
        check("R8 empty data", fifo_data, 0);
        check("R8 empty wraps", fifo_ovf, 0);

        // R9: disabled capture, then re-enable with a steady pin
        cap_en = 1'b0;
        pulse_in = ~pulse_in;
        cycles(6);
        check("R9 no capture while off", fifo_level, 0);
        cap_en = 1'b1;
        cycles(6);
        check("R9 no capture on re-enable", fifo_level, 0);

        // R10: flag, mask, clear, and capture in the same cycle as a clear
        irq_clr = 1'b1;
        cycles(1);
        irq_clr = 1'b0;
        check("R10 flag cleared", irq_flag, 0);
        irq_mask = 1'b1;
        pulse_in = ~pulse_in;
        cycles(4);
        check("R10 flag set", irq_flag, 1);
        check("R10 irq unmasked", irq, 1);
        irq_mask = 1'b0;
        cycles(1);
        check("R10 irq masked", irq, 0);
        irq_clr = 1'b1;
        cycles(1);
        irq_clr = 1'b0;
        check("R10 flag cleared by write", irq_flag, 0);
        pulse_in = ~pulse_in;
        cycles(2);
        irq_clr = 1'b1;
        cycles(1);
        irq_clr = 1'b0;
        check("R10 capture beats clear", irq_flag, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule